// File: doc/BRIEF.md
# Fixed-Latency Read Memory Queue Adapter

This block sits between a client and a synchronous read-only memory port whose data arrives a fixed `LAT` cycles after the read strobe. It gives the client a request/response interface with back-pressure. The client offers an address. Once the adapter grants it, the address goes to the memory in the same cycle. The word that returns is stored in a small response queue. From there the client can look at the oldest word for as long as it needs, and then remove it with a separate pop.

A down-counter of free response slots decides whether a request is accepted. A slot is reserved when the request is accepted, not when its data arrives, so a returning word always has a place in the queue and the memory is never stalled. A one-bit tag travels through a `LAT`-stage shift register next to each read. When the tag leaves the last stage, it writes the memory's read data into the queue. When the queue holds at least `LAT + 2` entries, the client can issue one read per cycle indefinitely, provided it pops one word per cycle.

Top module: `lat_mem_wrap`

## Requirements
- R1: A request accepted in cycle t when the queue is empty shows up as `rsp_valid` = 1 in cycle t+LAT+1, and not before. It carries the word that the memory drove on `mem_rd_data` in cycle t+LAT.
- R2: `req_ready` is 1 exactly when the free-slot counter is nonzero. A request is accepted when `req_valid` and `req_ready` are both 1. In that cycle `mem_rd_en` = 1 and `mem_rd_addr` = `req_addr`. Otherwise `mem_rd_en` = 0.
- R3: The free-slot counter resets to `DEPTH`. It decrements on an accepted request and increments on an effective pop. It stays unchanged when both happen in the same cycle.
- R4: Responses leave the queue in the order in which their requests were accepted.
- R5: While `rsp_valid` = 1 and `rsp_pop` = 0, `rsp_valid` stays 1 and `rsp_data` holds its value in the next cycle. `rsp_data` is always the oldest stored word.
- R6: The queue never receives a word while it is full. After `DEPTH` accepted requests with no pops, `req_ready` is 0 until a pop.
- R7: `rsp_valid` is 1 only while the queue is non-empty. A pop while `rsp_valid` = 0 has no effect, including on the free-slot counter.
- R8: With `DEPTH` >= `LAT`+2 and a pop in every cycle where `rsp_valid` = 1, `req_ready` stays 1 throughout a back-to-back request stream.
- R9: After reset, `req_ready` = 1, `rsp_valid` = 0, and `mem_rd_en` = 0 while `req_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client offers a read request |
| req_addr | input | ADDR_W | Address of the offered read |
| req_ready | output | 1 | A response slot is free; a request is accepted this cycle |
| rsp_valid | output | 1 | The queue holds at least one word |
| rsp_data | output | DATA_W | Oldest word in the queue |
| rsp_pop | input | 1 | Remove the oldest word |
| mem_rd_en | output | 1 | Read strobe to the memory |
| mem_rd_addr | output | ADDR_W | Read address to the memory |
| mem_rd_data | input | DATA_W | Memory read data, valid LAT cycles after the strobe |

## Verification
A wrong count in the free-slot counter shows up at the ports as `req_ready` in the wrong state. If the counter counts too high, the adapter accepts more than `DEPTH` reads during a fill without pops. If it counts too low, `req_ready` drops early, either during a full-rate stream or right after a cycle that both accepted and popped. Either error is visible within one fill of the queue. A misaligned tag pipe shifts the cycle at which `rsp_valid` rises away from t+LAT+1, or captures a neighbouring word. The bench sees this on the first isolated read, because each address maps to a distinct word. Broken queue pointers show up as out-of-order or changing `rsp_data` during a drain.

// File: rtl/lmw_pkg.sv
package lmw_pkg;

  typedef enum logic [1:0] {
    CR_HOLD = 2'd0,
    CR_TAKE = 2'd1,
    CR_GIVE = 2'd2
  } credit_op_e;

endpackage

// File: rtl/lmw_credit.sv
module lmw_credit #(
  parameter int DEPTH = 5,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  output logic [CW-1:0] credit,
  output logic          avail
);
  import lmw_pkg::*;

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  credit_op_e    op;
  logic [CW-1:0] credit_d;
  logic [CW-1:0] credit_q;
  logic          credit_en;

  always_comb begin
    op = CR_HOLD;
    if (take && !give) op = CR_TAKE;
    if (give && !take) op = CR_GIVE;
  end

  always_comb begin
    credit_d  = credit_q;
    credit_en = 1'b0;
    case (op)
      CR_TAKE: begin credit_d = credit_q - 1'b1; credit_en = 1'b1; end
      CR_GIVE: begin credit_d = credit_q + 1'b1; credit_en = 1'b1; end
      default: begin credit_d = credit_q;        credit_en = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         credit_q <= FULL;
    else if (credit_en) credit_q <= credit_d;
  end

  assign credit = credit_q;
  assign avail  = (credit_q != '0);

endmodule

// File: rtl/lmw_tag_pipe.sv
module lmw_tag_pipe #(
  parameter int LAT = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tag_in,
  output logic           tag_out,
  output logic [LAT-1:0] stages
);
  logic [LAT-1:0] stage_q;
  logic [LAT-1:0] stage_d;

  generate
    for (genvar s = 0; s < LAT; s++) begin : g_stage
      if (s == 0) begin : g_head
        assign stage_d[s] = tag_in;
      end else begin : g_body
        assign stage_d[s] = stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign tag_out = stage_q[LAT-1];
  assign stages  = stage_q;

endmodule

// File: rtl/lmw_rsp_fifo.sv
module lmw_rsp_fifo #(
  parameter int DEPTH  = 5,
  parameter int DATA_W = 8,
  parameter int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int OW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  output logic              nonempty,
  output logic [OW-1:0]     occ
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DATA_W-1:0] store_q [DEPTH];
  logic [PW-1:0]     wptr_q, wptr_d;
  logic [PW-1:0]     rptr_q, rptr_d;
  logic [OW-1:0]     occ_q,  occ_d;
  logic              rd_eff;

  assign rd_eff = rd && (occ_q != '0);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    occ_d  = occ_q;
    if (wr)     wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    if (rd_eff) rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    if (wr && !rd_eff) occ_d = occ_q + 1'b1;
    if (rd_eff && !wr) occ_d = occ_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      occ_q  <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) store_q[wptr_q] <= wdata;
  end

  assign rdata    = store_q[rptr_q];
  assign nonempty = (occ_q != '0);
  assign occ      = occ_q;

endmodule

// File: rtl/lat_mem_wrap.sv
module lat_mem_wrap #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int LAT    = 3,
  parameter int DEPTH  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_pop,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data
);
  localparam int CW = $clog2(DEPTH + 1);

  initial begin
    if (LAT < 1 || DEPTH < LAT) $error("lat_mem_wrap: need LAT >= 1 and DEPTH >= LAT");
  end

  logic           accept;
  logic           pop_eff;
  logic           credit_ok;
  logic [CW-1:0]  credit_q;
  logic           tag_out;
  logic [LAT-1:0] tag_stages;
  logic [CW-1:0]  fifo_occ;
  logic           fifo_nonempty;

  assign accept  = req_valid && credit_ok;
  assign pop_eff = rsp_pop && fifo_nonempty;

  lmw_credit #(.DEPTH(DEPTH), .CW(CW)) u_credit (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (accept),
    .give   (pop_eff),
    .credit (credit_q),
    .avail  (credit_ok)
  );

  lmw_tag_pipe #(.LAT(LAT)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .tag_in  (accept),
    .tag_out (tag_out),
    .stages  (tag_stages)
  );

  lmw_rsp_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .OW(CW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (tag_out),
    .wdata    (mem_rd_data),
    .rd       (pop_eff),
    .rdata    (rsp_data),
    .nonempty (fifo_nonempty),
    .occ      (fifo_occ)
  );

  assign req_ready   = credit_ok;
  assign rsp_valid   = fifo_nonempty;
  assign mem_rd_en   = accept;
  assign mem_rd_addr = req_addr;

endmodule

// File: rtl/lmw_checker.sv
module lmw_checker #(
  parameter int LAT    = 3,
  parameter int DEPTH  = 5,
  parameter int DATA_W = 8,
  parameter int CW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_pop,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mem_rd_en,
  input logic [CW-1:0]     credit,
  input logic [CW-1:0]     occ,
  input logic [LAT-1:0]    tags,
  input logic              fifo_wr
);

  assert_grant_needs_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (req_valid && credit != '0));

  assert_slot_balance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(credit) + int'(occ) + $countones(tags)) == DEPTH);

  assert_hold_oldest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_pop) |=> (rsp_valid && $stable(rsp_data)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (int'(occ) < DEPTH || rsp_pop));

  assert_empty_pop_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid && rsp_pop && !mem_rd_en) |=> $stable(credit));

endmodule

bind lat_mem_wrap lmw_checker #(
  .LAT(LAT), .DEPTH(DEPTH), .DATA_W(DATA_W), .CW(CW)
) u_lmw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_pop   (rsp_pop),
  .rsp_data  (rsp_data),
  .mem_rd_en (mem_rd_en),
  .credit    (credit_q),
  .occ       (fifo_occ),
  .tags      (tag_stages),
  .fifo_wr   (tag_out)
);

// File: tb/test_lat_mem_wrap.sv
`timescale 1ns/1ps
module test_lat_mem_wrap;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int LAT    = 3;
  localparam int DEPTH  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_pop = 1'b0;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [DATA_W-1:0] mem_rd_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  lat_mem_wrap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT), .DEPTH(DEPTH)) i_lat_mem_wrap (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_pop(rsp_pop),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [DATA_W-1:0] word_of(input int a);
    return DATA_W'((a * 29 + 7) % 256);
  endfunction

  // memory model: fixed LAT-cycle read latency
  logic [DATA_W-1:0] mpipe [LAT];
  always @(posedge clk) begin
    mpipe[0] <= mem_rd_en ? word_of(int'(mem_rd_addr)) : 8'h00;
    for (int s = 1; s < LAT; s++) mpipe[s] <= mpipe[s-1];
  end
  assign mem_rd_data = mpipe[LAT-1];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  int expq [$];

  // drain the queue, comparing order against expq
  task automatic drain(input string req);
    int guard = 0;
    while (expq.size() > 0 && guard < 50) begin
      tick();
      guard++;
      rsp_pop = 1'b0;
      if (rsp_valid) begin
        int e = expq.pop_front();
        check(rsp_data == word_of(e), req, int'(rsp_data), int'(word_of(e)));
        rsp_pop = 1'b1;
      end
    end
    check(guard < 50, req, guard, 0);
    tick();
    rsp_pop = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int acc;
    int seen;
    int sent;
    logic [DATA_W-1:0] held;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R9 reset state
    check(req_ready == 1'b1, "R9 req_ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R9 rsp_valid", int'(rsp_valid), 0);
    check(mem_rd_en == 1'b0, "R9 mem_rd_en", int'(mem_rd_en), 0);

    // R1/R2 single read latency
    req_valid = 1'b1; req_addr = 4'd5;
    #1;
    check(mem_rd_en == 1'b1, "R2 strobe", int'(mem_rd_en), 1);
    check(mem_rd_addr == 4'd5, "R2 addr", int'(mem_rd_addr), 5);
    tick();
    req_valid = 1'b0;
    for (int k = 1; k <= LAT; k++) begin
      check(rsp_valid == 1'b0, "R1 early", int'(rsp_valid), 0);
      if (k < LAT) tick();
    end
    tick();
    check(rsp_valid == 1'b1, "R1 arrival", int'(rsp_valid), 1);
    check(rsp_data == word_of(5), "R1 data", int'(rsp_data), int'(word_of(5)));
    rsp_pop = 1'b1;
    tick();
    rsp_pop = 1'b0;
    check(rsp_valid == 1'b0, "R7 empty after pop", int'(rsp_valid), 0);

    // R8/R4 full-rate sweep over all addresses with continuous pops
    sent = 0; seen = 0;
    while (seen < 16 && cyc < 5000) begin
      if (sent < 16) begin
        check(req_ready == 1'b1, "R8 ready in stream", int'(req_ready), 1);
        req_valid = 1'b1; req_addr = ADDR_W'(sent);
        sent++;
      end else begin
        req_valid = 1'b0;
      end
      rsp_pop = 1'b0;
      if (rsp_valid) begin
        check(rsp_data == word_of(seen), "R4 order", int'(rsp_data), int'(word_of(seen)));
        seen++;
        rsp_pop = 1'b1;
      end
      tick();
    end
    req_valid = 1'b0; rsp_pop = 1'b0;
    check(seen == 16, "R8 sweep count", seen, 16);
    tick();

    // R6/R2 fill without pops
    acc = 0;
    for (int k = 0; k < 12; k++) begin
      req_valid = 1'b1; req_addr = ADDR_W'(15 - k);
      #1;
      if (req_ready) begin
        acc++;
        expq.push_back(15 - k);
      end else begin
        check(mem_rd_en == 1'b0, "R2 no strobe when blocked", int'(mem_rd_en), 0);
      end
      tick();
    end
    req_valid = 1'b0;
    check(acc == DEPTH, "R6 accepted in fill", acc, DEPTH);
    check(req_ready == 1'b0, "R6 ready low when full", int'(req_ready), 0);

    // R5 oldest word holds without pop
    held = rsp_data;
    check(held == word_of(15), "R5 oldest", int'(held), int'(word_of(15)));
    repeat (3) begin
      tick();
      check(rsp_valid && rsp_data == held, "R5 stable", int'(rsp_data), int'(held));
    end
    drain("R4 drain order");

    // R7 pop while empty ignored
    rsp_pop = 1'b1;
    repeat (4) begin
      tick();
      check(rsp_valid == 1'b0, "R7 stays empty", int'(rsp_valid), 0);
    end
    rsp_pop = 1'b0;
    acc = 0;
    for (int k = 0; k < 10; k++) begin
      req_valid = 1'b1; req_addr = ADDR_W'(k);
      #1;
      if (req_ready) begin acc++; expq.push_back(k); end
      tick();
    end
    req_valid = 1'b0;
    check(acc == DEPTH, "R7 credit unchanged by empty pop", acc, DEPTH);
    drain("R4 second drain");

    // R3 accept and pop in one cycle keep the counter
    for (int k = 0; k < DEPTH - 1; k++) begin
      req_valid = 1'b1; req_addr = ADDR_W'(k + 3);
      expq.push_back(k + 3);
      tick();
    end
    req_valid = 1'b0;
    repeat (LAT + 2) tick();
    check(req_ready == 1'b1, "R3 one slot left", int'(req_ready), 1);
    req_valid = 1'b1; req_addr = 4'd9; rsp_pop = 1'b1;
    void'(expq.pop_front());
    expq.push_back(9);
    tick();
    rsp_pop = 1'b0;
    check(req_ready == 1'b1, "R3 accept+pop hold", int'(req_ready), 1);
    req_addr = 4'd10;
    expq.push_back(10);
    tick();
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R3 counter reaches zero", int'(req_ready), 0);
    repeat (LAT + 1) tick();
    drain("R4 third drain");
    check(req_ready == 1'b1, "R3 counter back to full", int'(req_ready), 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule